// File: doc/BRIEF.md
# Packed SIMD Saturating Subtractor

This block takes two packed operand vectors and subtracts the second from the first, lane by lane. Each lane result is clamped to the range its lane can hold, so overflow never wraps. Lane width is picked for every operation from 8, 16, 32 or 64 bits, and the lanes are read either as two's-complement or as unsigned integers. A vector-width control treats the operands as one 64-bit vector or as one 128-bit vector.

Operands and controls are captured on a valid strobe. One clock later the block presents the result, a per-lane saturation mask and a sticky flag that collects saturation across operations. The sticky flag stays set until a clear input lowers it. A pipeline stage in a vector unit would use this block to run saturating subtract operations and to collect a cumulative overflow indication.

Top module: `simd_sat_sub`

## Requirements
- R1: A lane that does not overflow holds the first operand's lane minus the second operand's lane, in the same bit position as its operands.
- R2: `sizeSel` picks the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes.
- R3: `isUnsigned`=0 treats lanes as two's-complement and `isUnsigned`=1 treats them as unsigned. The same operand bits can give different results in the two modes.
- R4: `wideVec`=0 selects a 64-bit vector. Result bits [127:64] are zero, and lanes above bit 63 never saturate, never set mask bits and never set the sticky flag. `wideVec`=1 selects a 128-bit vector.
- R5: An unsigned lane whose first operand is smaller than its second gives 0.
- R6: A signed lane whose true difference is above the lane maximum gives the maximum (0111...1). A signed lane whose true difference is below the lane minimum gives the minimum (1000...0).
- R7: `satMask` bit i is set when lane i (counted from the least significant lane) saturated. Bits at or above the number of active lanes are zero.
- R8: `satSticky` goes to 1 after any accepted operation that saturates in an active lane. It then stays at 1 until it is cleared.
- R9: A cycle with `clearSat`=1 and no saturating accepted operation leaves `satSticky` at 0. When a clear and a saturating operation arrive in the same cycle, `satSticky` ends at 1.
- R10: `outValid` is `inValid` delayed by one clock. `result` and `satMask` change only in the clock after an accepted operation and hold their values otherwise. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accepts operands and controls this cycle |
| opA | input | 128 | Minuend vector |
| opB | input | 128 | Subtrahend vector |
| sizeSel | input | 2 | Lane width code |
| isUnsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| wideVec | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| clearSat | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result registers hold a new operation |
| result | output | 128 | Clamped difference vector |
| satMask | output | 16 | Per-lane saturation mask |
| satSticky | output | 1 | Cumulative saturation flag |

## Verification
Every datapath defect shows at the ports one clock after the operation that triggers it. A wrong lane split, a wrong overflow test or a wrong clamp value shows in `result` and `satMask` in the very next valid cycle. An inactive upper lane that leaks saturation shows in `satSticky` in that same cycle. A sticky register that loses its value, or does not keep priority over a clear, shows only on the first later operation that samples it. For that reason the stimulus puts clears next to saturating and non-saturating operations and checks the flag after every cycle.

// File: rtl/satsub_pkg.sv
package satsub_pkg;

  // Strobes issued by the control unit to the datapath registers.
  typedef struct packed {
    logic captureResult;  // load result and saturation mask
    logic captureCfg;     // load the configuration of the accepted op
  } dpStrobe_t;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } laneSize_e;

endpackage

// File: rtl/satsub_datapath.sv
module satsub_datapath
  import satsub_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int GRAN_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [VEC_W-1:0]            opA,
  input  logic [VEC_W-1:0]            opB,
  input  logic [1:0]                  sizeSel,
  input  logic                        isUnsigned,
  input  logic                        wideVec,
  output logic                        anySat,
  output logic [VEC_W-1:0]            result,
  output logic [VEC_W/GRAN_W-1:0]     satMask
);

  localparam int NUM_GRAN  = VEC_W / GRAN_W;
  localparam int NUM_SIZES = 4;
  localparam int HALF_W    = VEC_W / 2;

  // Every lane width is built in parallel; the size code picks one.
  logic [NUM_SIZES*VEC_W-1:0]    resFlat;
  logic [NUM_SIZES*NUM_GRAN-1:0] satFlat;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = GRAN_W << s;
    localparam int NL = VEC_W / LW;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      localparam bit UPPER = ((l + 1) * LW) > HALF_W;
      logic [LW-1:0] laneA, laneB, diff, clamped;
      logic          sOvf, uUnd, sat, active;

      assign laneA  = opA[l*LW +: LW];
      assign laneB  = opB[l*LW +: LW];
      assign active = wideVec | ~UPPER;

      always_comb begin
        diff = laneA - laneB;
        sOvf = (laneA[LW-1] ^ laneB[LW-1]) & (diff[LW-1] ^ laneA[LW-1]);
        uUnd = laneA < laneB;
        if (isUnsigned) begin
          sat     = uUnd;
          clamped = uUnd ? '0 : diff;
        end else begin
          sat = sOvf;
          if (!sOvf)
            clamped = diff;
          else if (laneA[LW-1])
            clamped = {1'b1, {(LW-1){1'b0}}};
          else
            clamped = {1'b0, {(LW-1){1'b1}}};
        end
      end

      assign resFlat[s*VEC_W + l*LW +: LW] = active ? clamped : '0;
      assign satFlat[s*NUM_GRAN + l]        = active & sat;
    end

    if (NL < NUM_GRAN) begin : g_pad
      assign satFlat[s*NUM_GRAN + NL +: NUM_GRAN - NL] = '0;
    end
  end

  logic [VEC_W-1:0]    selRes;
  logic [NUM_GRAN-1:0] selSat;

  assign selRes = resFlat[sizeSel*VEC_W +: VEC_W];
  assign selSat = satFlat[sizeSel*NUM_GRAN +: NUM_GRAN];
  assign anySat = |selSat;

  logic [VEC_W-1:0]    resultQ;
  logic [NUM_GRAN-1:0] satMaskQ;
  logic                wideQ;
  laneSize_e           sizeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      satMaskQ <= '0;
    end else if (strobe.captureResult) begin
      resultQ  <= selRes;
      satMaskQ <= selSat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ <= 1'b0;
      sizeQ <= LANE_8;
    end else if (strobe.captureCfg) begin
      wideQ <= wideVec;
      sizeQ <= laneSize_e'(sizeSel);
    end
  end

  assign result  = resultQ;
  assign satMask = satMaskQ;

  // Checker-side count of active lanes for the registered configuration.
  int activeLanes;
  always_comb activeLanes = (wideQ ? NUM_GRAN : NUM_GRAN / 2) >> sizeQ;

  // R4: a 64-bit vector operation leaves the upper half of the result zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wideQ |-> (resultQ[VEC_W-1:HALF_W] == '0));

  // R7: no mask bit at or above the active lane count
  assert_mask_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (32'(satMaskQ) >> activeLanes) == 32'd0);

  // R10: result and mask hold when nothing is accepted
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureResult |=> ($stable(resultQ) && $stable(satMaskQ)));

endmodule

// File: rtl/satsub_ctrl.sv
module satsub_ctrl
  import satsub_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      clearSat,
  input  logic      anySat,
  output dpStrobe_t strobe,
  output logic      outValid,
  output logic      satSticky
);

  logic validQ, stickyQ;

  always_comb begin
    strobe.captureResult = inValid;
    strobe.captureCfg    = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      stickyQ <= 1'b0;
    end else begin
      validQ  <= inValid;
      stickyQ <= (stickyQ & ~clearSat) | (inValid & anySat);
    end
  end

  assign outValid  = validQ;
  assign satSticky = stickyQ;

  // R8: a saturating accepted operation sets the flag
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && anySat) |=> stickyQ);

  // R8: the flag holds without a clear
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stickyQ && !clearSat) |=> stickyQ);

  // R9: a clear with no saturating operation lowers the flag
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearSat && !(inValid && anySat)) |=> !stickyQ);

  // R10: valid output follows valid input by one clock
  assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validQ);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !validQ);

endmodule

// File: rtl/simd_sat_sub.sv
module simd_sat_sub
  import satsub_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [1:0]   sizeSel,
  input  logic         isUnsigned,
  input  logic         wideVec,
  input  logic         clearSat,
  output logic         outValid,
  output logic [127:0] result,
  output logic [15:0]  satMask,
  output logic         satSticky
);

  dpStrobe_t strobe;
  logic      anySat;

  satsub_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .clearSat  (clearSat),
    .anySat    (anySat),
    .strobe    (strobe),
    .outValid  (outValid),
    .satSticky (satSticky)
  );

  satsub_datapath #(.VEC_W(128), .GRAN_W(8)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .sizeSel    (sizeSel),
    .isUnsigned (isUnsigned),
    .wideVec    (wideVec),
    .anySat     (anySat),
    .result     (result),
    .satMask    (satMask)
  );

endmodule

// File: tb/test_simd_sat_sub.sv
`timescale 1ns/1ps
module test_simd_sat_sub;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [1:0]   sizeSel = '0;
  logic         isUnsigned = 1'b0, wideVec = 1'b0, clearSat = 1'b0;
  logic         outValid;
  logic [127:0] result;
  logic [15:0]  satMask;
  logic         satSticky;

  int checks = 0;
  int fails  = 0;
  logic         expSticky = 1'b0;
  logic [127:0] lastRes = '0;
  logic [15:0]  lastMask = '0;

  always #2.5 clk = ~clk;

  simd_sat_sub i_simd_sat_sub (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .sizeSel(sizeSel), .isUnsigned(isUnsigned), .wideVec(wideVec),
    .clearSat(clearSat), .outValid(outValid), .result(result),
    .satMask(satMask), .satSticky(satSticky)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: true difference in wide arithmetic, compared with lane limits.
  task automatic model(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                       input logic uns, input logic wide,
                       output logic [127:0] r, output logic [15:0] m);
    int lw = 8 << sz;
    int nl = 128 / lw;
    logic [63:0] wmask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    r = '0; m = '0;
    for (int l = 0; l < nl; l++) begin
      logic [63:0] av, bv, rv;
      logic [65:0] ta, tb;
      logic signed [65:0] sa, sb, tr, maxv, minv;
      logic sat;
      if (!wide && (l + 1) * lw > 64) continue;
      av = 64'(a >> (l * lw)) & wmask;
      bv = 64'(b >> (l * lw)) & wmask;
      sat = 1'b0;
      if (uns) begin
        if (av < bv) begin rv = '0; sat = 1'b1; end
        else rv = av - bv;
      end else begin
        ta = {2'b00, av} << (66 - lw);
        tb = {2'b00, bv} << (66 - lw);
        sa = $signed(ta) >>> (66 - lw);
        sb = $signed(tb) >>> (66 - lw);
        tr = sa - sb;
        maxv = (66'sd1 <<< (lw - 1)) - 66'sd1;
        minv = -(66'sd1 <<< (lw - 1));
        if (tr > maxv)      begin rv = maxv[63:0]; sat = 1'b1; end
        else if (tr < minv) begin rv = minv[63:0]; sat = 1'b1; end
        else rv = tr[63:0];
      end
      r = r | (128'(rv & wmask) << (l * lw));
      m[l] = sat;
    end
  endtask

  task automatic doOp(input string tag, input logic [127:0] a, input logic [127:0] b,
                      input logic [1:0] sz, input logic uns, input logic wide, input logic clr);
    logic [127:0] er;
    logic [15:0]  em;
    @(negedge clk);
    opA = a; opB = b; sizeSel = sz; isUnsigned = uns; wideVec = wide;
    clearSat = clr; inValid = 1'b1;
    model(a, b, sz, uns, wide, er, em);
    expSticky = (expSticky & ~clr) | (|em);
    @(negedge clk);
    inValid = 1'b0; clearSat = 1'b0;
    check({tag, " R10 valid"}, 128'(outValid), 128'd1);
    check({tag, " result"}, result, er);
    check({tag, " R7 mask"}, 128'(satMask), 128'(em));
    check({tag, " R8 sticky"}, 128'(satSticky), 128'(expSticky));
    lastRes = er; lastMask = em;
  endtask

  function automatic logic [127:0] fill(input logic [63:0] v, input int lw);
    logic [127:0] r = '0;
    for (int l = 0; l < 128 / lw; l++) r = r | (128'(v) << (l * lw));
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset valid", 128'(outValid), 128'd0);
    check("R10 reset result", result, '0);
    check("R10 reset mask", 128'(satMask), '0);
    check("R10 reset sticky", 128'(satSticky), '0);

    // R1: plain differences without overflow
    doOp("R1 small", fill(64'h0a, 8), fill(64'h03, 8), 2'b00, 1'b0, 1'b1, 1'b0);
    // R3: same bits, different results by signedness
    doOp("R3 signed", fill(64'h80, 8), fill(64'h01, 8), 2'b00, 1'b0, 1'b1, 1'b0);
    doOp("R3 unsigned", fill(64'h80, 8), fill(64'h01, 8), 2'b00, 1'b1, 1'b1, 1'b1);

    // R2, R5, R6: extreme cases for every lane width and mode
    for (int sz = 0; sz < 4; sz++) begin
      for (int u = 0; u < 2; u++) begin
        int lw = 8 << sz;
        logic [63:0] wm = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        logic [63:0] mn = u ? 64'd0 : (64'd1 << (lw - 1));
        logic [63:0] mx = u ? wm : ((64'd1 << (lw - 1)) - 64'd1);
        doOp(u ? "R5 R2 min-max" : "R6 R2 min-max", fill(mn, lw), fill(mx, lw), 2'(sz), 1'(u), 1'b1, 1'b0);
        doOp(u ? "R5 R2 max-min" : "R6 R2 max-min", fill(mx, lw), fill(mn, lw), 2'(sz), 1'(u), 1'b1, 1'b0);
        doOp(u ? "R5 R2 zero-one" : "R6 R2 zero-one", '0, fill(64'd1, lw), 2'(sz), 1'(u), 1'b1, 1'b0);
      end
    end

    // R9: clear alone, then hold check of result (R10)
    @(negedge clk); clearSat = 1'b1;
    @(negedge clk); clearSat = 1'b0; expSticky = 1'b0;
    check("R9 clear alone", 128'(satSticky), 128'd0);
    check("R10 idle valid", 128'(outValid), 128'd0);
    check("R10 hold result", result, lastRes);
    check("R10 hold mask", 128'(satMask), 128'(lastMask));

    // R4: upper half saturating, lower half clean, 64-bit mode
    doOp("R4 narrow", {64'h0, 64'h5}, {64'hffff_ffff_ffff_ffff, 64'h1}, 2'b00, 1'b1, 1'b0, 1'b0);
    check("R4 narrow sticky", 128'(satSticky), 128'd0);
    // R9: clear and saturate together leaves flag set
    doOp("R9 clear+sat", '0, fill(64'd1, 16), 2'b01, 1'b1, 1'b1, 1'b1);
    check("R9 clear+sat sticky", 128'(satSticky), 128'd1);
    // R8: non-saturating op keeps the flag
    doOp("R8 keep", fill(64'd9, 32), fill(64'd2, 32), 2'b10, 1'b1, 1'b1, 1'b0);

    // Random mix of operands, including extreme lanes
    for (int i = 0; i < 600; i++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a = ($urandom_range(0, 1) != 0) ? '1 : {1'b1, 127'd0};
      if ($urandom_range(0, 3) == 0) b = ($urandom_range(0, 1) != 0) ? '0 : {1'b0, {127{1'b1}}};
      doOp("R1 R3 random", a, b, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule